// File: doc/BRIEF.md
# Host Command Mailbox Register Block

This block is the register face of a one-deep command channel between a host and a service processor. The host fills a source pointer, a destination pointer and up to four 32-bit input words, then writes a command word. Writing the command word starts the exchange: the block latches the word, marks itself busy and holds a request line high toward the service port, where the latched command, pointers and input words are presented in parallel.

The service side ends the exchange with a one-cycle done pulse that carries an error flag, an 8-bit error code and four response words. The block stores them, drops busy and, if the latched command asked for it, raises a host interrupt. The host reads the outcome from the status register and the response buffer. It clears the interrupt by writing the status register with bit 2 set.

Control is a two-state machine. In `ST_IDLE` the transition CMD_ACCEPT fires on a host write to the command register and leads to `ST_BUSY`. In `ST_BUSY` the transition COMPLETE fires on the service done pulse and returns to `ST_IDLE`. Any other input leaves the state unchanged.

Top module: `mbox_regs`

## Requirements
- R1: A synchronous active-high reset clears every register and buffer. After reset, status reads 0, `svc_req` is 0 and `host_irq` is 0.
- R2: A host write to offset 0x00 while idle latches the full word, which then reads back at 0x00 and appears on `svc_cmd`. From the next cycle status bit 0 (busy) reads 1 and `svc_req` is 1.
- R3: A write to offset 0x00 while busy is ignored, and the latched command word stays unchanged.
- R4: A `svc_done` pulse while busy clears busy on the next cycle. It also stores `svc_err` in status bit 1, `svc_code` in status bits 23:16 and the four response words, which read at 0x90, 0x94, 0x98 and 0x9C (word 0 is `svc_resp[31:0]`).
- R5: Status bit 2 (the interrupt flag) is set by completion only when bit 8 of the latched command is 1. `host_irq` always equals this flag. The block decodes no other command field: code 7:0, sub-command 15:12 and byte length 23:16 pass through unchanged.
- R6: A host write to offset 0x04 with bit 2 set clears the interrupt flag. Every other status bit ignores host writes, and a write with bit 2 clear changes nothing.
- R7: Reads of unmapped offsets return 0. Host writes to the response buffer or to unmapped offsets change no readable state.
- R8: A `svc_done` pulse while idle is ignored, and status stays as it was.
- R9: Source pointer (0x08), destination pointer (0x0C) and input words (0x80, 0x84, 0x88, 0x8C) are host read/write. They are driven on `svc_src`, `svc_dst` and `svc_in_data` (word 0 in bits 31:0).
- R10: Accepting a new command clears the stored error flag and error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one word per cycle |
| bus_addr | input | 8 | Host byte offset for read and write |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for `bus_addr`, combinational |
| svc_req | output | 1 | Command pending toward the service processor |
| svc_cmd | output | 32 | Latched command word |
| svc_src | output | 32 | Source pointer |
| svc_dst | output | 32 | Destination pointer |
| svc_in_data | output | 128 | Four input words |
| svc_done | input | 1 | Completion pulse from the service side |
| svc_err | input | 1 | Error flag that goes with `svc_done` |
| svc_code | input | 8 | Error code that goes with `svc_done` |
| svc_resp | input | 128 | Four response words that go with `svc_done` |
| host_irq | output | 1 | Completion interrupt toward the host |

## Verification
The bound checker watches the handshake on every cycle:
- a command write while idle raises the request;
- a command write while busy leaves the latched word stable;
- completion drops the request;
- a stray done pulse while idle starts nothing;
- the interrupt rises only on a completion whose command had bit 8 set, and falls after a write-one-to-clear.

The per-cycle reference model in the bench covers what only data can show: exact status packing with the error code at bits 23:16, response words landing in the right slots, pointer and input read-back, zero on unmapped reads, and error fields cleared by the next accepted command.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } mbox_state_e;

    // byte offsets of the host-visible registers
    localparam int OFS_CMD  = 'h00;
    localparam int OFS_STS  = 'h04;
    localparam int OFS_SRC  = 'h08;
    localparam int OFS_DST  = 'h0C;
    localparam int OFS_IN   = 'h80;
    localparam int OFS_RESP = 'h90;

    // field positions
    localparam int CMD_IRQ_BIT  = 8;
    localparam int STS_BUSY_BIT = 0;
    localparam int STS_ERR_BIT  = 1;
    localparam int STS_IRQ_BIT  = 2;
    localparam int STS_CODE_LSB = 16;
    localparam int CODE_W       = 8;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic svc_done,
    output logic busy,
    output logic accept,
    output logic finish
);

    mbox_state_e state_q;
    mbox_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_wr)   state_d = ST_BUSY;  // CMD_ACCEPT
            ST_BUSY: if (svc_done) state_d = ST_IDLE;  // COMPLETE
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        finish = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = cmd_wr;
            ST_BUSY: begin
                busy   = 1'b1;
                finish = svc_done;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mbox_wordbuf.sv
module mbox_wordbuf #(
    parameter int NWORDS = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     ld_en,
    input  logic [NWORDS*DATA_W-1:0] ld_data,
    output logic [NWORDS*DATA_W-1:0] q
);

    // a parallel load wins over a single-word write
    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                q[i*DATA_W +: DATA_W] <= '0;
            else if (ld_en)
                q[i*DATA_W +: DATA_W] <= ld_data[i*DATA_W +: DATA_W];
            else if (wr_en && (wr_idx == IDX_W'(i)))
                q[i*DATA_W +: DATA_W] <= wr_data;
        end
    end

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     svc_req,
    output logic [DATA_W-1:0]        svc_cmd,
    output logic [DATA_W-1:0]        svc_src,
    output logic [DATA_W-1:0]        svc_dst,
    output logic [NWORDS*DATA_W-1:0] svc_in_data,
    input  logic                     svc_done,
    input  logic                     svc_err,
    input  logic [CODE_W-1:0]        svc_code,
    input  logic [NWORDS*DATA_W-1:0] svc_resp,
    output logic                     host_irq
);

    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int RGN_LSB = IDX_W + 2;
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFS_SRC);
    localparam logic [ADDR_W-1:0] A_DST  = ADDR_W'(OFS_DST);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(OFS_RESP);

    logic              busy, accept, finish;
    logic [DATA_W-1:0] cmd_q, src_q, dst_q, status_w;
    logic              err_q, irq_q;
    logic [CODE_W-1:0] code_q;
    logic [NWORDS*DATA_W-1:0] in_q, resp_q;
    logic              hit_in, hit_resp;
    logic [IDX_W-1:0]  word_idx;

    assign hit_in   = (bus_addr[ADDR_W-1:RGN_LSB] == A_IN[ADDR_W-1:RGN_LSB])
                      && (bus_addr[1:0] == 2'b00);
    assign hit_resp = (bus_addr[ADDR_W-1:RGN_LSB] == A_RESP[ADDR_W-1:RGN_LSB])
                      && (bus_addr[1:0] == 2'b00);
    assign word_idx = bus_addr[RGN_LSB-1:2];

    mbox_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (bus_wr && (bus_addr == A_CMD)),
        .svc_done (svc_done),
        .busy     (busy),
        .accept   (accept),
        .finish   (finish)
    );

    mbox_wordbuf #(.NWORDS(NWORDS), .DATA_W(DATA_W)) u_inbuf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && hit_in),
        .wr_idx  (word_idx),
        .wr_data (bus_wdata),
        .ld_en   (1'b0),
        .ld_data ('0),
        .q       (in_q)
    );

    mbox_wordbuf #(.NWORDS(NWORDS), .DATA_W(DATA_W)) u_respbuf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (1'b0),
        .wr_idx  ('0),
        .wr_data ('0),
        .ld_en   (finish),
        .ld_data (svc_resp),
        .q       (resp_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            err_q  <= 1'b0;
            code_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q  <= bus_wdata;
                err_q  <= 1'b0;
                code_q <= '0;
            end
            if (finish) begin
                err_q  <= svc_err;
                code_q <= svc_code;
            end
            if (finish && cmd_q[CMD_IRQ_BIT])
                irq_q <= 1'b1;
            else if (bus_wr && (bus_addr == A_STS) && bus_wdata[STS_IRQ_BIT])
                irq_q <= 1'b0;
            if (bus_wr && (bus_addr == A_SRC)) src_q <= bus_wdata;
            if (bus_wr && (bus_addr == A_DST)) dst_q <= bus_wdata;
        end
    end

    always_comb begin
        status_w = '0;
        status_w[STS_BUSY_BIT] = busy;
        status_w[STS_ERR_BIT]  = err_q;
        status_w[STS_IRQ_BIT]  = irq_q;
        status_w[STS_CODE_LSB +: CODE_W] = code_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CMD)      bus_rdata = cmd_q;
        else if (bus_addr == A_STS) bus_rdata = status_w;
        else if (bus_addr == A_SRC) bus_rdata = src_q;
        else if (bus_addr == A_DST) bus_rdata = dst_q;
        else if (hit_in)            bus_rdata = in_q[word_idx*DATA_W +: DATA_W];
        else if (hit_resp)          bus_rdata = resp_q[word_idx*DATA_W +: DATA_W];
    end

    assign svc_req     = busy;
    assign svc_cmd     = cmd_q;
    assign svc_src     = src_q;
    assign svc_dst     = dst_q;
    assign svc_in_data = in_q;
    assign host_irq    = irq_q;

endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              svc_done,
    input logic [DATA_W-1:0] svc_cmd,
    input logic              svc_req,
    input logic              host_irq
);

    logic cmd_wr, sts_clr;
    assign cmd_wr  = bus_wr && (bus_addr == ADDR_W'(0));
    assign sts_clr = bus_wr && (bus_addr == ADDR_W'(4)) && bus_wdata[2];

    p_reset_r1: assert property (@(posedge clk) rst |=> !svc_req && !host_irq);

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !svc_req |=> svc_req);

    p_hold_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && svc_req |=> $stable(svc_cmd));

    p_complete_r4: assert property (@(posedge clk) disable iff (rst)
        svc_req && svc_done |=> !svc_req);

    p_irq_set_r5: assert property (@(posedge clk) disable iff (rst)
        svc_req && svc_done && svc_cmd[8] |=> host_irq);

    p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(host_irq) |-> $past(svc_req && svc_done && svc_cmd[8]));

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
        host_irq && sts_clr && !(svc_req && svc_done) |=> !host_irq);

    p_stray_done_r8: assert property (@(posedge clk) disable iff (rst)
        !svc_req && svc_done && !cmd_wr |=> !svc_req);

endmodule

bind mbox_regs mbox_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .svc_done  (svc_done),
    .svc_cmd   (svc_cmd),
    .svc_req   (svc_req),
    .host_irq  (host_irq)
);

// File: tb/test_mbox_regs.sv
module test_mbox_regs;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         svc_req;
    logic [31:0]  svc_cmd, svc_src, svc_dst;
    logic [127:0] svc_in_data;
    logic         svc_done = 1'b0;
    logic         svc_err = 1'b0;
    logic [7:0]   svc_code = '0;
    logic [127:0] svc_resp = '0;
    logic         host_irq;

    always #4 clk = ~clk;  // 125 MHz

    mbox_regs i_mbox_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .svc_req(svc_req),
        .svc_cmd(svc_cmd), .svc_src(svc_src), .svc_dst(svc_dst),
        .svc_in_data(svc_in_data), .svc_done(svc_done), .svc_err(svc_err),
        .svc_code(svc_code), .svc_resp(svc_resp), .host_irq(host_irq)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit started = 0;
    bit ended = 0;

    // behavioural reference state
    logic [31:0] m_cmd = 0, m_src = 0, m_dst = 0;
    logic [31:0] m_in [4] = '{default: 0};
    logic [31:0] m_resp [4] = '{default: 0};
    bit m_busy = 0, m_err = 0, m_irq = 0;
    logic [7:0] m_code = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_rd(logic [7:0] a);
        if (a == 8'h00) return m_cmd;
        if (a == 8'h04) return {8'h00, m_code, 13'h0, m_irq, m_err, m_busy};
        if (a == 8'h08) return m_src;
        if (a == 8'h0C) return m_dst;
        if (a[7:4] == 4'h8 && a[1:0] == 2'b00) return m_in[a[3:2]];
        if (a[7:4] == 4'h9 && a[1:0] == 2'b00) return m_resp[a[3:2]];
        return 32'h0;
    endfunction

    function automatic string rd_tag(logic [7:0] a);
        if (a == 8'h00) return "R2";
        if (a == 8'h04) return "R4";
        if (a == 8'h08 || a == 8'h0C || a[7:4] == 4'h8) return "R9";
        if (a[7:4] == 4'h9) return "R4";
        return "R7";
    endfunction

    // model update at the active edge, from the inputs driven 1 ns after the previous edge
    always @(posedge clk) begin
        if (rst) begin
            m_cmd = 0; m_src = 0; m_dst = 0; m_busy = 0; m_err = 0; m_irq = 0; m_code = 0;
            for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_resp[i] = 0; end
            started = 1;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            if (bus_wr && bus_addr == 8'h00 && !was_busy) begin
                m_cmd = bus_wdata; m_busy = 1; m_err = 0; m_code = 0;
            end
            if (bus_wr && bus_addr == 8'h04 && bus_wdata[2]) m_irq = 0;
            if (was_busy && svc_done) begin
                m_busy = 0; m_err = svc_err; m_code = svc_code;
                for (int i = 0; i < 4; i++) m_resp[i] = svc_resp[i*32 +: 32];
                if (m_cmd[8]) m_irq = 1;
            end
            if (bus_wr && bus_addr == 8'h08) m_src = bus_wdata;
            if (bus_wr && bus_addr == 8'h0C) m_dst = bus_wdata;
            if (bus_wr && bus_addr[7:4] == 4'h8 && bus_addr[1:0] == 2'b00)
                m_in[bus_addr[3:2]] = bus_wdata;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !ended) begin
            check(rd_tag(bus_addr), bus_rdata, m_rd(bus_addr));
            check("R2", {31'h0, svc_req}, {31'h0, m_busy});
            check("R5", {31'h0, host_irq}, {31'h0, m_irq});
            check("R3", svc_cmd, m_cmd);
            check("R9", svc_src, m_src);
            check("R9", svc_dst, m_dst);
            for (int i = 0; i < 4; i++) check("R9", svc_in_data[i*32 +: 32], m_in[i]);
        end
    end

    // all tasks start and end 1 ns after a rising edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        bus_addr = a; #1;
        check(tag, bus_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic finish_cmd(bit e, logic [7:0] c, logic [127:0] r);
        svc_done = 1; svc_err = e; svc_code = c; svc_resp = r;
        @(posedge clk); #1;
        svc_done = 0; svc_err = 0; svc_code = 0; svc_resp = 0;
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        rd(8'h04, 32'h0, "R1");
        check("R1", {31'h0, svc_req}, 32'h0);
        check("R1", {31'h0, host_irq}, 32'h0);

        // R9: pointers and input words
        wr(8'h08, 32'h1000_0040);
        wr(8'h0C, 32'h2000_0080);
        for (int i = 0; i < 4; i++) wr(8'h80 + 8'(4*i), 32'hA5A5_0000 + i);
        rd(8'h84, 32'hA5A5_0001, "R9");
        rd(8'h0C, 32'h2000_0080, "R9");

        // R2: accept with interrupt request (bit 8), length 16, sub 1, code 5
        wr(8'h00, 32'h0010_1105);
        check("R2", {31'h0, svc_req}, 32'h1);
        rd(8'h04, 32'h1, "R2");

        // R3: second command while busy is ignored
        wr(8'h00, 32'h0000_0002);
        rd(8'h00, 32'h0010_1105, "R3");

        // R6: status write while busy leaves busy set
        wr(8'h04, 32'hFFFF_FFFB);
        rd(8'h04, 32'h1, "R6");

        // R4, R5: completion with error and code
        finish_cmd(1, 8'h5A, {32'hD3, 32'hC2, 32'hB1, 32'hA0});
        rd(8'h04, 32'h005A_0006, "R4");
        check("R5", {31'h0, host_irq}, 32'h1);
        rd(8'h98, 32'hC2, "R4");

        // R7: response buffer and unmapped writes ignored, unmapped reads zero
        wr(8'h90, 32'hDEAD_BEEF);
        wr(8'h40, 32'h1234_5678);
        rd(8'h90, 32'hA0, "R7");
        rd(8'h40, 32'h0, "R7");
        rd(8'h82, 32'h0, "R7");

        // R6: write without bit 2 keeps the flag, with bit 2 clears it
        wr(8'h04, 32'h0000_0003);
        rd(8'h04, 32'h005A_0006, "R6");
        wr(8'h04, 32'h0000_0004);
        rd(8'h04, 32'h005A_0002, "R6");

        // R8: stray done while idle
        finish_cmd(0, 8'h11, {4{32'hFFFF_FFFF}});
        rd(8'h04, 32'h005A_0002, "R8");
        rd(8'h9C, 32'hD3, "R8");

        // R10: new command clears error fields; no bit 8 so no interrupt
        wr(8'h00, 32'h0000_0033);
        rd(8'h04, 32'h1, "R10");
        finish_cmd(0, 8'h00, {32'h4, 32'h3, 32'h2, 32'h1});
        rd(8'h04, 32'h0, "R5");
        check("R5", {31'h0, host_irq}, 32'h0);

        // back-to-back: accept right after completion, then clear during busy
        wr(8'h00, 32'h0000_0177);
        finish_cmd(0, 8'h00, {4{32'h55}});
        wr(8'h00, 32'h0000_0101);
        wr(8'h04, 32'h4);
        finish_cmd(1, 8'hFF, {4{32'h66}});
        rd(8'h04, 32'h00FF_0006, "R4");

        // R1: reset in the middle of a pending command
        wr(8'h00, 32'h0000_0100);
        rst = 1; @(posedge clk); #1 rst = 0;
        rd(8'h04, 32'h0, "R1");
        rd(8'h80, 32'h0, "R1");

        repeat (4) @(posedge clk);
        report();
    end

endmodule